// File: doc/BRIEF.md
# DMA Burst Planner

This block cuts one DMA buffer transfer into a series of bus bursts. A transfer request carries a start byte address, a length in 4-byte beats and the burst-shaping controls. These are a 6-bit programmed burst length, a times-four scaling bit, a fixed-burst bit, an address-aligned bit and a mixed-burst bit. While busy, the planner shows one burst at a time: its start address, its beat count and its AHB burst code. It moves to the next burst when the downstream bus master accepts the current one.

The planner contains no bus cycles, no data movement and no descriptor logic. It only decides where each burst starts, how long it is and which burst type announces it. It also keeps every burst inside a 1 KB address window. A one-cycle done pulse marks the end of each transfer, and a new request is taken only while the block is idle.

Top module: `dma_burst_planner`

## Requirements
- R1: While reset is applied and in the first cycle after it, `bst_valid` and `xfer_done` are 0 and `req_ready` is 1.
- R2: The effective burst limit is the programmed length, or four times it when `cfg_x4` is 1. A programmed length of 0 counts as 1. No burst is longer than this limit or than the beats still remaining.
- R3: With `cfg_fixed` and `cfg_mixed` both 0, each burst has type INCR (code 1). Its length is the smallest of the remaining beats, the effective limit and the beats left before the next 1 KB boundary. Each burst starts at the previous start plus 4 bytes per beat.
- R4: No burst crosses a 1 KB address boundary. A burst that would cross one is cut short at the boundary.
- R5: With `cfg_fixed` 1, each burst is 16, 8, 4 or 1 beats long, using the largest size that fits the limits of R2 and R4. The codes are INCR16=7, INCR8=5, INCR4=3 and SINGLE=0.
- R6: With `cfg_fixed` and `cfg_align` both 1, a 16-, 8- or 4-beat burst starts only on a byte boundary of its own length times 4. Where no such size fits, a SINGLE burst is issued.
- R7: With `cfg_align` 1 and `cfg_fixed` 0, let U be the largest power of two not above the effective limit. No burst runs past a U-beat boundary, so a misaligned first burst is shortened and every later burst starts aligned.
- R8: With `cfg_mixed` 1 and `cfg_fixed` 0, a burst whose allowed length exceeds 16 beats is issued as INCR with that length. Otherwise the burst is chosen as in R5.
- R9: A burst is taken on a clock edge where `bst_valid` and `bst_ready` are both 1. While `bst_valid` is 1 and `bst_ready` is 0, the burst outputs hold steady.
- R10: `xfer_done` is 1 for exactly the one cycle after the final burst is taken. A request of 0 beats issues no burst and gives `xfer_done` in the cycle after it is accepted.
- R11: `req_ready` is 1 only while no transfer is in progress. A `req_valid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request strobe |
| req_ready | output | 1 | Idle, request can be taken |
| req_addr | input | 32 | Transfer start byte address |
| req_beats | input | 16 | Transfer length in 4-byte beats |
| cfg_pbl | input | 6 | Programmed burst length |
| cfg_x4 | input | 1 | Scale burst length by four |
| cfg_fixed | input | 1 | Fixed-length bursts only |
| cfg_align | input | 1 | Address-aligned bursts |
| cfg_mixed | input | 1 | INCR above 16 beats, fixed types at or below |
| bst_valid | output | 1 | Burst descriptor present |
| bst_ready | input | 1 | Burst taken by downstream master |
| bst_addr | output | 32 | Burst start byte address |
| bst_len | output | 9 | Burst length in beats |
| bst_type | output | 3 | AHB burst code |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench targets a transfer that starts four beats below a 1 KB boundary. A planner that ignores the boundary would issue one 16-beat burst across it. Fixed mode is driven with odd remainders, where a wrong selection would emit a length such as 13 with no matching burst code. Aligned fixed mode starts from an address two beats into a block, where a careless design issues INCR4 or INCR8 on a misaligned address. Further cases are a misaligned first burst in aligned INCR mode, the INCR-to-INCR4 handover of mixed mode, a zero-length request, a request raised while busy, and a held burst under back-pressure. Each of these would show an extra burst, a lost burst, or a shifted address or length.

// File: rtl/dma_bp_pkg.sv
`timescale 1ns/1ps
package dma_bp_pkg;
  typedef enum logic [2:0] {
    HB_SINGLE = 3'd0,
    HB_INCR   = 3'd1,
    HB_INCR4  = 3'd3,
    HB_INCR8  = 3'd5,
    HB_INCR16 = 3'd7
  } hburst_e;

  typedef struct packed {
    logic [5:0] pbl;
    logic       x4;
    logic       fixed;
    logic       align;
    logic       mixed;
  } bp_cfg_t;
endpackage

// File: rtl/dma_bp_rst_sync.sv
`timescale 1ns/1ps
module dma_bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_bp_limit.sv
`timescale 1ns/1ps
module dma_bp_limit #(
  parameter int CNT_W       = 16,
  parameter int LEN_W       = 9,
  parameter int BOUND_BYTES = 1024
) (
  input  logic [$clog2(BOUND_BYTES)-3:0] beat_ofs,
  input  logic [CNT_W-1:0]               remain,
  input  logic [LEN_W-1:0]               epbl,
  input  logic                           align_on,
  output logic [LEN_W-1:0]               cap
);
  localparam int BOUND_BEATS = BOUND_BYTES / 4;

  logic [CNT_W-1:0] to_bound, unit, offs, to_unit, lim_a, lim_b;

  always_comb begin
    to_bound = CNT_W'(BOUND_BEATS) - CNT_W'(beat_ofs);
    unit = CNT_W'(1);
    for (int i = 0; i < LEN_W; i++) begin
      if (epbl[i]) unit = CNT_W'(1) << i;
    end
    offs    = CNT_W'(beat_ofs) & (unit - CNT_W'(1));
    to_unit = unit - offs;
    lim_a   = (remain < CNT_W'(epbl)) ? remain : CNT_W'(epbl);
    lim_b   = (lim_a < to_bound) ? lim_a : to_bound;
    if (align_on && (to_unit < lim_b)) lim_b = to_unit;
    cap = LEN_W'(lim_b);
  end
endmodule

// File: rtl/dma_bp_shape.sv
`timescale 1ns/1ps
module dma_bp_shape
  import dma_bp_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic [LEN_W-1:0] cap,
  input  logic [3:0]       beat_lo,
  input  logic             fixed_on,
  input  logic             align_on,
  input  logic             mixed_on,
  output logic [LEN_W-1:0] len,
  output hburst_e          btype
);
  logic use_fixed, need_al, ok16, ok8, ok4;

  always_comb begin
    use_fixed = fixed_on || (mixed_on && (cap <= LEN_W'(16)));
    need_al   = fixed_on && align_on;
    ok16 = (cap >= LEN_W'(16)) && (!need_al || (beat_lo == 4'd0));
    ok8  = (cap >= LEN_W'(8))  && (!need_al || (beat_lo[2:0] == 3'd0));
    ok4  = (cap >= LEN_W'(4))  && (!need_al || (beat_lo[1:0] == 2'd0));
    if (!use_fixed) begin
      len = cap;             btype = HB_INCR;
    end else if (ok16) begin
      len = LEN_W'(16);      btype = HB_INCR16;
    end else if (ok8) begin
      len = LEN_W'(8);       btype = HB_INCR8;
    end else if (ok4) begin
      len = LEN_W'(4);       btype = HB_INCR4;
    end else begin
      len = LEN_W'(1);       btype = HB_SINGLE;
    end
  end
endmodule

// File: rtl/dma_burst_planner.sv
`timescale 1ns/1ps
module dma_burst_planner
  import dma_bp_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int PBL_W       = 6,
  parameter int LEN_W       = 9,
  parameter int BOUND_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_beats,
  input  logic [PBL_W-1:0]  cfg_pbl,
  input  logic              cfg_x4,
  input  logic              cfg_fixed,
  input  logic              cfg_align,
  input  logic              cfg_mixed,
  output logic              bst_valid,
  input  logic              bst_ready,
  output logic [ADDR_W-1:0] bst_addr,
  output logic [LEN_W-1:0]  bst_len,
  output logic [2:0]        bst_type,
  output logic              xfer_done
);
  localparam int BLSB = $clog2(BOUND_BYTES);

  logic              srst_n;
  logic              busy_q, busy_d, done_q, done_d, ld_en;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  bp_cfg_t           cfg_q, cfg_d;
  logic [PBL_W-1:0]  pbl_base;
  logic [LEN_W-1:0]  epbl, cap, len;
  hburst_e           btype;
  logic              accept, fire;

  dma_bp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    pbl_base = (cfg_q.pbl == '0) ? PBL_W'(1) : cfg_q.pbl;
    epbl     = cfg_q.x4 ? (LEN_W'(pbl_base) << 2) : LEN_W'(pbl_base);
  end

  dma_bp_limit #(.CNT_W(CNT_W), .LEN_W(LEN_W), .BOUND_BYTES(BOUND_BYTES)) u_limit (
    .beat_ofs(addr_q[BLSB-1:2]),
    .remain  (rem_q),
    .epbl    (epbl),
    .align_on(cfg_q.align && !cfg_q.fixed),
    .cap     (cap)
  );

  dma_bp_shape #(.LEN_W(LEN_W)) u_shape (
    .cap     (cap),
    .beat_lo (addr_q[5:2]),
    .fixed_on(cfg_q.fixed),
    .align_on(cfg_q.align),
    .mixed_on(cfg_q.mixed),
    .len     (len),
    .btype   (btype)
  );

  // next-state
  always_comb begin
    accept = req_valid && !busy_q;
    fire   = busy_q && bst_ready;
    busy_d = busy_q;
    done_d = 1'b0;
    ld_en  = 1'b0;
    addr_d = addr_q;
    rem_d  = rem_q;
    cfg_d  = cfg_q;
    if (accept) begin
      ld_en  = 1'b1;
      addr_d = req_addr;
      rem_d  = req_beats;
      cfg_d  = '{pbl: cfg_pbl, x4: cfg_x4, fixed: cfg_fixed,
                 align: cfg_align, mixed: cfg_mixed};
      busy_d = (req_beats != '0);
      done_d = (req_beats == '0);
    end else if (fire) begin
      ld_en  = 1'b1;
      addr_d = addr_q + (ADDR_W'(len) << 2);
      rem_d  = rem_q - CNT_W'(len);
      if (rem_q == CNT_W'(len)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      cfg_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (ld_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        cfg_q  <= cfg_d;
      end
    end
  end

  assign req_ready = !busy_q;
  assign bst_valid = busy_q;
  assign bst_addr  = addr_q;
  assign bst_len   = len;
  assign bst_type  = btype;
  assign xfer_done = done_q;
endmodule

// File: rtl/dma_burst_planner_chk.sv
`timescale 1ns/1ps
module dma_burst_planner_chk
  import dma_bp_pkg::*;
#(
  parameter int LEN_W       = 9,
  parameter int BOUND_BYTES = 1024
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_ready,
  input logic                          bst_valid,
  input logic                          bst_ready,
  input logic [$clog2(BOUND_BYTES)-1:0] addr_lo,
  input logic [LEN_W-1:0]              bst_len,
  input logic [2:0]                    bst_type,
  input logic                          xfer_done
);
  localparam int SW = $clog2(BOUND_BYTES) + LEN_W + 2;
  logic [SW-1:0] span_end;
  assign span_end = SW'(addr_lo) + (SW'(bst_len) << 2);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid && !bst_ready |=> bst_valid && $stable(addr_lo) &&
                                 $stable(bst_len) && $stable(bst_type));

  a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> span_end <= SW'(BOUND_BYTES));

  a_r5_type_len: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (bst_type == HB_INCR) ||
                  (bst_type == HB_SINGLE && bst_len == LEN_W'(1)) ||
                  (bst_type == HB_INCR4  && bst_len == LEN_W'(4)) ||
                  (bst_type == HB_INCR8  && bst_len == LEN_W'(8)) ||
                  (bst_type == HB_INCR16 && bst_len == LEN_W'(16)));

  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> bst_len != '0 && bst_len <= LEN_W'(252));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !bst_valid && req_ready);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

bind dma_burst_planner dma_burst_planner_chk #(
  .LEN_W(LEN_W), .BOUND_BYTES(BOUND_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .bst_valid(bst_valid),
  .bst_ready(bst_ready),
  .addr_lo  (bst_addr[$clog2(BOUND_BYTES)-1:0]),
  .bst_len  (bst_len),
  .bst_type (bst_type),
  .xfer_done(xfer_done)
);

// File: tb/dma_burst_planner_test.sv
`timescale 1ns/1ps
module dma_burst_planner_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_beats;
  logic [5:0]  cfg_pbl;
  logic        cfg_x4, cfg_fixed, cfg_align, cfg_mixed;
  logic        bst_valid, bst_ready;
  logic [31:0] bst_addr;
  logic [8:0]  bst_len;
  logic [2:0]  bst_type;
  logic        xfer_done;

  int checks = 0;
  int fails  = 0;

  localparam logic [2:0] T_S = 3'd0, T_I = 3'd1, T_I4 = 3'd3, T_I8 = 3'd5, T_I16 = 3'd7;

  always #2.5 clk = ~clk;

  dma_burst_planner uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats),
    .cfg_pbl(cfg_pbl), .cfg_x4(cfg_x4), .cfg_fixed(cfg_fixed),
    .cfg_align(cfg_align), .cfg_mixed(cfg_mixed),
    .bst_valid(bst_valid), .bst_ready(bst_ready),
    .bst_addr(bst_addr), .bst_len(bst_len), .bst_type(bst_type),
    .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_req(input logic [31:0] a, input logic [15:0] n,
                           input logic [5:0] p, input logic x4,
                           input logic fx, input logic al, input logic mx);
    @(negedge clk);
    req_addr = a; req_beats = n; cfg_pbl = p; cfg_x4 = x4;
    cfg_fixed = fx; cfg_align = al; cfg_mixed = mx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // called at a negedge; takes one burst and checks it
  task automatic take_burst(input string req, input logic [31:0] a,
                            input logic [8:0] l, input logic [2:0] t,
                            input bit last);
    for (int n = 0; n < 20 && !bst_valid; n++) @(negedge clk);
    chk(req, "valid", 32'(bst_valid), 32'd1);
    chk(req, "addr", bst_addr, a);
    chk(req, "len", 32'(bst_len), 32'(l));
    chk(req, "type", 32'(bst_type), 32'(t));
    bst_ready = 1'b1;
    @(negedge clk);
    bst_ready = 1'b0;
    if (last) begin
      chk("R10", "done after last", 32'(xfer_done), 32'd1);
      chk("R10", "no burst after last", 32'(bst_valid), 32'd0);
      @(negedge clk);
      chk("R10", "done one cycle", 32'(xfer_done), 32'd0);
      chk("R11", "idle ready", 32'(req_ready), 32'd1);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; bst_ready = 1'b0;
    req_addr = '0; req_beats = '0; cfg_pbl = '0;
    cfg_x4 = 0; cfg_fixed = 0; cfg_align = 0; cfg_mixed = 0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", 32'(bst_valid), 32'd0);
    chk("R1", "ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "valid after reset", 32'(bst_valid), 32'd0);
    chk("R1", "done after reset", 32'(xfer_done), 32'd0);
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
  endtask

  task automatic t_x4_incr_hold;   // R2 R3 R9
    start_req(32'h100, 16'd40, 6'd8, 1'b1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R9", "held addr", bst_addr, 32'h100);
    chk("R9", "held len", 32'(bst_len), 32'd32);
    take_burst("R2", 32'h100, 9'd32, T_I, 0);
    take_burst("R3", 32'h180, 9'd8, T_I, 1);
  endtask

  task automatic t_pbl_zero;       // R2
    start_req(32'h40, 16'd2, 6'd0, 1'b0, 0, 0, 0);
    take_burst("R2", 32'h40, 9'd1, T_I, 0);
    take_burst("R2", 32'h44, 9'd1, T_I, 1);
  endtask

  task automatic t_bound;          // R4
    start_req(32'h3F0, 16'd20, 6'd16, 1'b0, 0, 0, 0);
    take_burst("R4", 32'h3F0, 9'd4, T_I, 0);
    take_burst("R4", 32'h400, 9'd16, T_I, 1);
  endtask

  task automatic t_fixed;          // R5
    start_req(32'h0, 16'd29, 6'd16, 1'b0, 1, 0, 0);
    take_burst("R5", 32'h00, 9'd16, T_I16, 0);
    take_burst("R5", 32'h40, 9'd8, T_I8, 0);
    take_burst("R5", 32'h60, 9'd4, T_I4, 0);
    take_burst("R5", 32'h70, 9'd1, T_S, 1);
  endtask

  task automatic t_fixed_align;    // R6
    start_req(32'h8, 16'd20, 6'd16, 1'b0, 1, 1, 0);
    take_burst("R6", 32'h08, 9'd1, T_S, 0);
    take_burst("R6", 32'h0C, 9'd1, T_S, 0);
    take_burst("R6", 32'h10, 9'd4, T_I4, 0);
    take_burst("R6", 32'h20, 9'd8, T_I8, 0);
    take_burst("R6", 32'h40, 9'd4, T_I4, 0);
    take_burst("R6", 32'h50, 9'd1, T_S, 0);
    take_burst("R6", 32'h54, 9'd1, T_S, 1);
  endtask

  task automatic t_align_incr;     // R7
    start_req(32'h14, 16'd40, 6'd16, 1'b0, 0, 1, 0);
    take_burst("R7", 32'h14, 9'd11, T_I, 0);
    take_burst("R7", 32'h40, 9'd16, T_I, 0);
    take_burst("R7", 32'h80, 9'd13, T_I, 1);
  endtask

  task automatic t_mixed;          // R8
    start_req(32'h0, 16'd70, 6'd8, 1'b1, 0, 0, 1);
    take_burst("R8", 32'h000, 9'd32, T_I, 0);
    take_burst("R8", 32'h080, 9'd32, T_I, 0);
    take_burst("R8", 32'h100, 9'd4, T_I4, 0);
    take_burst("R8", 32'h110, 9'd1, T_S, 0);
    take_burst("R8", 32'h114, 9'd1, T_S, 1);
  endtask

  task automatic t_zero_len;       // R10
    start_req(32'h200, 16'd0, 6'd8, 1'b0, 0, 0, 0);
    chk("R10", "zero done", 32'(xfer_done), 32'd1);
    chk("R10", "zero no burst", 32'(bst_valid), 32'd0);
    @(negedge clk);
    chk("R10", "zero done clears", 32'(xfer_done), 32'd0);
    chk("R10", "zero still idle", 32'(bst_valid), 32'd0);
  endtask

  task automatic t_busy_ignore;    // R11
    start_req(32'h200, 16'd8, 6'd8, 1'b0, 0, 0, 0);
    chk("R11", "ready low busy", 32'(req_ready), 32'd0);
    req_addr = 32'h0; req_beats = 16'd4; cfg_fixed = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    take_burst("R11", 32'h200, 9'd8, T_I, 1);
    chk("R11", "no extra burst", 32'(bst_valid), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_x4_incr_hold();
    t_pbl_zero();
    t_bound();
    t_fixed();
    t_fixed_align();
    t_align_incr();
    t_mixed();
    t_zero_len();
    t_busy_ignore();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule